// File: doc/BRIEF.md
# Grouped Port Interrupt Combiner

This block watches a large set of input pins spread over several ports and folds them into a single interrupt request. Software gives each pin an enable bit and a sense bit. The block brings every pin into the local clock domain, marks an enabled pin as active when its level matches its sense bit, and then merges the active pins. The merge is either "any enabled pin active" or "every enabled pin active".

A control register selects the merge function and the trigger style. In edge style, a rising transition of the merged condition sets a sticky status bit, and software clears that bit by writing one to it. In level style, the status bit tracks the merged condition. The interrupt output is the status bit. Software reaches all registers through a simple write-strobe register port with a combinational read path.

Top module: `grpint_top`

## Requirements
- R1: After reset, the control, sense and enable registers all read 0, and `irq` is low.
- R2: A pin is active only when its enable bit is 1 and its synchronized level equals its sense bit (sense 1 = active high, sense 0 = active low). A pin whose enable bit is 0 has no effect on `irq`.
- R3: With control bit 1 at 0, the merged condition is true when at least one enabled pin is active.
- R4: With control bit 1 at 1, the merged condition is true when every enabled pin is active. With no pin enabled, the condition is false.
- R5: With control bit 2 at 0 (edge style), a 0-to-1 transition of the merged condition sets status bit 0. The bit stays set after the condition falls.
- R6: In edge style, a control write with bit 0 at 1 clears the status. A write with bit 0 at 0 leaves it unchanged. A rising transition in the same cycle as a clearing write wins, so the bit stays set. A held condition does not set the bit again after a clear.
- R7: With control bit 2 at 1 (level style), the status bit equals the merged condition one cycle later. A clearing write while the condition holds leaves the bit set.
- R8: `irq` equals control bit 0 as read through the register port.
- R9: Register map on `reg_addr`: 0 is control (bit 0 status, bit 1 merge, bit 2 trigger; bits 31:3 read 0). 8+n is the sense register of port n. 16+n is the enable register of port n. Each port uses bits PORT_W-1:0, and PORT_W is at most 32.
- R10: A pin change reaches `irq` through two synchronizer flops plus the status flop. If the pin is driven before a clock edge, `irq` responds after the third edge and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| port_pins | input | NUM_PORTS*PORT_W | Pin levels, port n in bits n*PORT_W +: PORT_W |
| irq | output | 1 | Group interrupt request |

## Verification
The bench uses two ports of three pins each. In level style it sweeps every enable pattern against every pin pattern, with a sense pattern that changes along the sweep, in both merge functions. This catches a design that lets disabled pins through, inverts the sense bit, or treats an empty enable set as true in the all-active merge. In edge style it checks the following:
- The bit stays set after the condition drops, which catches a design whose status is not sticky.
- A zero-write has no effect.
- A clear while the condition is held does not re-trigger, which catches a design that sets on level instead of edge.
- In level style, a clear while the condition holds leaves the bit set.
- The exact three-edge pin latency holds, which catches a missing or extra synchronizer stage.

// File: rtl/grpint_pkg.sv
package grpint_pkg;
    localparam int unsigned REG_AW = 5;
    localparam logic [1:0]  SEL_CTRL = 2'b00;
    localparam logic [1:0]  SEL_SENSE = 2'b01;
    localparam logic [1:0]  SEL_EN = 2'b10;

    typedef struct packed {
        logic trig_level;
        logic merge_all;
        logic status;
    } ctrl_t;

    typedef struct packed {
        ctrl_t ctrl;
        logic  cond_prev;
    } stat_state_t;
endpackage

// File: rtl/grpint_sync.sv
module grpint_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int s = 1; s < int'(STAGES); s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/grpint_regs.sv
module grpint_regs
    import grpint_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 8,
    parameter int unsigned PORT_W    = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [REG_AW-1:0]             addr,
    input  logic [PORT_W-1:0]             wdata,
    input  ctrl_t                         ctrl,
    output logic [31:0]                   rdata,
    output logic [NUM_PORTS*PORT_W-1:0]   sense,
    output logic [NUM_PORTS*PORT_W-1:0]   enable
);
    typedef struct packed {
        logic [NUM_PORTS-1:0][PORT_W-1:0] sense;
        logic [NUM_PORTS-1:0][PORT_W-1:0] en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            for (int p = 0; p < int'(NUM_PORTS); p++) begin
                if (addr[2:0] == 3'(p)) begin
                    if (addr[4:3] == SEL_SENSE) cfg_d.sense[p] = wdata;
                    if (addr[4:3] == SEL_EN)    cfg_d.en[p]    = wdata;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata = '0;
        if (addr == '0) begin
            rdata = 32'(ctrl);
        end
        for (int p = 0; p < int'(NUM_PORTS); p++) begin
            if (addr[2:0] == 3'(p)) begin
                if (addr[4:3] == SEL_SENSE) rdata[PORT_W-1:0] = cfg_q.sense[p];
                if (addr[4:3] == SEL_EN)    rdata[PORT_W-1:0] = cfg_q.en[p];
            end
        end
    end

    assign sense  = cfg_q.sense;
    assign enable = cfg_q.en;
endmodule

// File: rtl/grpint_eval.sv
module grpint_eval #(
    parameter int unsigned N = 256
) (
    input  logic         merge_all,
    input  logic [N-1:0] pins,
    input  logic [N-1:0] sense,
    input  logic [N-1:0] enable,
    output logic         cond
);
    logic [N-1:0] active;
    logic         any_hit;
    logic         all_hit;

    always_comb begin
        active  = enable & ~(pins ^ sense);
        any_hit = |active;
        all_hit = (active == enable) && (|enable);
        cond    = merge_all ? all_hit : any_hit;
    end
endmodule

// File: rtl/grpint_status.sv
module grpint_status
    import grpint_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [2:0] wdata,
    input  logic       cond,
    output ctrl_t      ctrl
);
    stat_state_t st_d, st_q;
    logic        rise;

    always_comb begin
        st_d           = st_q;
        st_d.cond_prev = cond;
        rise           = cond && !st_q.cond_prev;
        if (ctrl_wr) begin
            st_d.ctrl.merge_all  = wdata[1];
            st_d.ctrl.trig_level = wdata[2];
        end
        if (st_q.ctrl.trig_level) begin
            st_d.ctrl.status = cond;
        end else begin
            if (ctrl_wr && wdata[0]) st_d.ctrl.status = 1'b0;
            if (rise)                st_d.ctrl.status = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl = st_q.ctrl;

    // R5: a rising condition in edge style always leaves the status set
    p_edge_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.trig_level && cond && !st_q.cond_prev) |=> st_q.ctrl.status);

    // R5: edge-style status is sticky without a control write
    p_edge_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.trig_level && st_q.ctrl.status && !ctrl_wr) |=> st_q.ctrl.status);

    // R6: a clearing write with no rising edge clears the status
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wdata[0] && !wdata[2] && !st_q.ctrl.trig_level
         && !(cond && !st_q.cond_prev)) |=> !st_q.ctrl.status);

    // R7: level-style status tracks the condition one cycle later
    p_level_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.trig_level && !ctrl_wr) |=> (st_q.ctrl.status == $past(cond)));
endmodule

// File: rtl/grpint_top.sv
module grpint_top
    import grpint_pkg::*;
#(
    parameter int unsigned NUM_PORTS   = 8,
    parameter int unsigned PORT_W      = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr,
    input  logic [4:0]                  reg_addr,
    input  logic [31:0]                 reg_wdata,
    output logic [31:0]                 reg_rdata,
    input  logic [NUM_PORTS*PORT_W-1:0] port_pins,
    output logic                        irq
);
    localparam int unsigned NPINS = NUM_PORTS * PORT_W;

    logic [NPINS-1:0] pins_sync;
    logic [NPINS-1:0] sense;
    logic [NPINS-1:0] enable;
    logic             cond;
    logic             ctrl_wr;
    ctrl_t            ctrl;

    assign ctrl_wr = reg_wr && (reg_addr == '0);

    grpint_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (port_pins),
        .dout (pins_sync)
    );

    grpint_regs #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata[PORT_W-1:0]),
        .ctrl  (ctrl),
        .rdata (reg_rdata),
        .sense (sense),
        .enable(enable)
    );

    grpint_eval #(.N(NPINS)) u_eval (
        .merge_all(ctrl.merge_all),
        .pins     (pins_sync),
        .sense    (sense),
        .enable   (enable),
        .cond     (cond)
    );

    grpint_status u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctrl_wr(ctrl_wr),
        .wdata  (reg_wdata[2:0]),
        .cond   (cond),
        .ctrl   (ctrl)
    );

    assign irq = ctrl.status;

    // R4: an empty enable set never makes the all-active merge true
    p_and_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.merge_all && enable == '0) |-> !cond);

    // R2: with nothing enabled the condition stays false in either merge
    p_none_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> !cond);
endmodule

// File: tb/test_grpint_top.sv
module test_grpint_top;
    localparam int NP = 2;
    localparam int PW = 3;
    localparam int NB = NP * PW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [4:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NB-1:0] port_pins = '0;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    grpint_top #(.NUM_PORTS(NP), .PORT_W(PW), .SYNC_STAGES(2)) i_grpint_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .port_pins(port_pins),
        .irq      (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] d;
        logic [NB-1:0] sen, act;
        logic exp;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        // R1: reset state
        check("R1 irq", 32'(irq), 0);
        rd(5'd0, d);  check("R1 ctrl", d, 0);
        rd(5'd8, d);  check("R1 sense", d, 0);
        rd(5'd17, d); check("R1 enable", d, 0);

        // R2 R3 R4: level-style sweep, all enables x all pin patterns
        for (int m = 0; m < 2; m++) begin
            wr(5'd0, 32'(4 + 2 * m));
            for (int e = 0; e < 64; e++) begin
                sen = NB'(e * 37 + 5);
                wr(5'd8, 32'(sen[2:0]));
                wr(5'd9, 32'(sen[5:3]));
                wr(5'd16, 32'(e % 8));
                wr(5'd17, 32'(e / 8));
                rd(5'd9, d); check("R9 sense readback", d, 32'(sen[5:3]));
                for (int p = 0; p < 64; p++) begin
                    port_pins = NB'(p);
                    wait_cyc(4);
                    act = NB'(e) & ~(NB'(p) ^ sen);
                    if (m == 0) exp = |act;
                    else        exp = (act == NB'(e)) && (e != 0);
                    check(m == 0 ? "R2 R3 merge any" : "R2 R4 merge all", 32'(irq), 32'(exp));
                end
            end
        end

        // edge style setup: only pin 0 enabled, active high
        port_pins = '0;
        wr(5'd8, 32'h1); wr(5'd9, 32'h0);
        wr(5'd16, 32'h1); wr(5'd17, 32'h0);
        wr(5'd0, 32'h0);
        wait_cyc(4);
        wr(5'd0, 32'h1);
        wait_cyc(2);
        check("R5 idle", 32'(irq), 0);
        rd(5'd0, d); check("R8 ctrl idle", d, 0);

        // R10: latency, pin driven at a negedge
        @(negedge clk);
        port_pins = 6'h01;
        wait_cyc(2);
        check("R10 not after two edges", 32'(irq), 0);
        wait_cyc(1);
        check("R10 after three edges", 32'(irq), 1);

        port_pins = '0;
        wait_cyc(4);
        check("R5 sticky", 32'(irq), 1);
        wr(5'd0, 32'h0);
        wait_cyc(2);
        check("R6 zero write", 32'(irq), 1);
        rd(5'd0, d); check("R8 status readback", d, 32'h1);
        wr(5'd0, 32'h1);
        wait_cyc(2);
        check("R6 clear", 32'(irq), 0);

        port_pins = 6'h01;
        wait_cyc(4);
        check("R5 second edge", 32'(irq), 1);
        wr(5'd0, 32'h1);
        wait_cyc(4);
        check("R6 held no retrigger", 32'(irq), 0);

        // R7: level style with condition held
        wr(5'd0, 32'h4);
        wait_cyc(1);
        check("R7 follow high", 32'(irq), 1);
        wr(5'd0, 32'h5);
        wait_cyc(1);
        check("R7 clear while held", 32'(irq), 1);
        port_pins = '0;
        wait_cyc(4);
        check("R7 follow low", 32'(irq), 0);

        // R9: reserved control bits read 0
        wr(5'd0, 32'hFFFF_FFF8);
        wait_cyc(1);
        rd(5'd0, d); check("R9 reserved bits", d, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule